// File: doc/BRIEF.md
# Zero-Cross Gain Update Controller

This block sits between a control register and a two-channel (left/right) input gain stage. Software writes a 7-bit gain code. The block holds that code as pending. Each channel then loads it at a moment when the change is least audible: when that channel's own sample stream crosses zero, or, failing that, when a timeout counter shared by both channels expires. The counter counts sample strobes.

A readback port always shows the last code written, whatever gain is actually applied. While automatic level control is enabled, writes reach only the readback value, and an external level-control gain drives both outputs. A power-mode field of zero forces both applied gains to the default code and cancels any pending update.

Applied gains are registered. A commit caused by the sample strobe seen at a clock edge is visible at the outputs right after that edge. The level-control override acts on the outputs combinationally.

Top module: `zc_gain_ctrl`

## Requirements
- R1: On a sample strobe, a channel that is waiting for an update sees a zero crossing when its sample is exactly zero, or when the sample's sign bit differs from the sign bit of that channel's previous strobed sample. The channel then loads the pending gain, independently of the other channel.
- R2: The shared timeout is 128, 256, 512 or 1024 sample strobes for a select value of 0, 1, 2 or 3. On the strobe that completes the timeout, counted from the write that armed the update, every channel still waiting loads the pending gain.
- R3: A write accepted while neither channel is waiting arms both channels and restarts the counter from zero. A write accepted while a channel is still waiting only replaces the pending code. It does not restart the counter and does not re-arm a channel that has already loaded. Such a channel keeps its gain, so the two channels may end up with different gains.
- R4: The readback output equals the most recent written gain code in every mode, including level control and power-down.
- R5: While level control is enabled and power is on, both gain outputs equal the level-control gain input, and writes do not arm an update. When level control is released, the outputs return to the gains held before it, and the level-control gain is not copied to readback.
- R6: While the power-mode field is 00, both applied gains are 0x10, waiting is cancelled, and writes do not arm an update. After the field leaves 00, the gains stay at 0x10 until a new write is committed.
- R7: After reset both gain outputs and the readback equal 0x10, and no channel is waiting.
- R8: Gains change only on a cycle with the sample strobe high, apart from power-down. The timeout counter advances only on strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe for both channels |
| smp_left | input | 16 | Signed left sample |
| smp_right | input | 16 | Signed right sample |
| wr_en | input | 1 | Gain register write strobe |
| wr_gain | input | 7 | Gain code to write |
| tmo_sel | input | 2 | Timeout select |
| lvl_en | input | 1 | Automatic level control enable |
| lvl_gain | input | 7 | Gain supplied by the level control |
| pwr_mode | input | 2 | Power mode; 00 powers the gain stage down |
| gain_left | output | 7 | Applied left gain |
| gain_right | output | 7 | Applied right gain |
| rd_gain | output | 7 | Readback of the last written gain |

## Verification
A wrong waiting flag or pending code appears at the gain outputs on the first strobe whose sample crosses zero. A counter that is off by one shows up on the strobe that should have completed the timeout. A counter restarted wrongly by a busy write delays the lagging channel by a whole timeout window. The bench models the block cycle by cycle and compares all three outputs after every clock edge, so a fault is reported within one cycle of the point where it becomes visible. Directed sequences line up crossings, timeouts, overlapping writes, level control and power-down so that each of these faults has a visible edge to land on.

// File: rtl/zc_gain_ctrl.sv
module zc_gain_ctrl #(
  parameter int GW = 7,
  parameter int SW = 16,
  parameter int TB = 7,
  parameter logic [GW-1:0] DEF_GAIN = 'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_left,
  input  logic [SW-1:0] smp_right,
  input  logic          wr_en,
  input  logic [GW-1:0] wr_gain,
  input  logic [1:0]    tmo_sel,
  input  logic          lvl_en,
  input  logic [GW-1:0] lvl_gain,
  input  logic [1:0]    pwr_mode,
  output logic [GW-1:0] gain_left,
  output logic [GW-1:0] gain_right,
  output logic [GW-1:0] rd_gain
);
  localparam int CW = TB + 3;

  logic [GW-1:0] gl, gr, pend;
  logic          wait_l, wait_r, sgn_l, sgn_r;
  logic [CW-1:0] cnt;
  logic [CW:0]   lim;

  wire pwr_on = |pwr_mode;
  wire busy   = wait_l | wait_r;
  wire arm_ok = wr_en & ~lvl_en & pwr_on;
  wire [GW-1:0] pend_nx = arm_ok ? wr_gain : pend;
  wire zc_l = smp_valid & ((smp_left == '0) | (smp_left[SW-1] != sgn_l));
  wire zc_r = smp_valid & ((smp_right == '0) | (smp_right[SW-1] != sgn_r));

  assign lim = (CW+1)'(1) << (TB + int'(tmo_sel));
  wire tmo = smp_valid & busy & ({1'b0, cnt} >= lim - 1'b1);

  assign gain_left  = (lvl_en & pwr_on) ? lvl_gain : gl;
  assign gain_right = (lvl_en & pwr_on) ? lvl_gain : gr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gl <= DEF_GAIN;
      gr <= DEF_GAIN;
      pend <= DEF_GAIN;
      rd_gain <= DEF_GAIN;
      wait_l <= 1'b0;
      wait_r <= 1'b0;
      sgn_l <= 1'b0;
      sgn_r <= 1'b0;
      cnt <= '0;
    end else begin
      if (smp_valid) begin
        sgn_l <= smp_left[SW-1];
        sgn_r <= smp_right[SW-1];
      end
      if (wr_en) rd_gain <= wr_gain;
      if (!pwr_on) begin
        gl <= DEF_GAIN;
        gr <= DEF_GAIN;
        wait_l <= 1'b0;
        wait_r <= 1'b0;
        cnt <= '0;
      end else begin
        pend <= pend_nx;
        if (arm_ok && !busy) begin
          wait_l <= 1'b1;
          wait_r <= 1'b1;
          cnt <= '0;
        end else if (busy && smp_valid) begin
          if (wait_l && (zc_l || tmo)) begin
            gl <= pend_nx;
            wait_l <= 1'b0;
          end
          if (wait_r && (zc_r || tmo)) begin
            gr <= pend_nx;
            wait_r <= 1'b0;
          end
          cnt <= tmo ? '0 : cnt + 1'b1;
        end
      end
    end
  end

  p_rd_last_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_gain == $past(wr_gain));

  p_pwrdn_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (gl == DEF_GAIN && gr == DEF_GAIN && !busy));

  p_strobe_needed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && pwr_on) |=> ($stable(gl) && $stable(gr)));

  p_lvl_no_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_en && !busy) |=> !busy);

  p_commit_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wait_l) && $past(pwr_on)) |-> gl == pend);

  p_commit_pending_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wait_r) && $past(pwr_on)) |-> gr == pend);
endmodule

// File: tb/test_zc_gain_ctrl.sv
module test_zc_gain_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [15:0] smp_left = '0, smp_right = '0;
  logic wr_en = 1'b0;
  logic [6:0] wr_gain = '0;
  logic [1:0] tmo_sel = 2'd0;
  logic lvl_en = 1'b0;
  logic [6:0] lvl_gain = '0;
  logic [1:0] pwr_mode = 2'd1;
  logic [6:0] gain_left, gain_right, rd_gain;

  int total = 0, bad = 0;
  string cur_req = "R7";
  int m_gl, m_gr, m_rd, m_pend, m_cnt;
  bit m_wl, m_wr, m_nl, m_nr;

  always #2 clk = ~clk;

  zc_gain_ctrl i_zc_gain_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right),
    .wr_en(wr_en), .wr_gain(wr_gain), .tmo_sel(tmo_sel),
    .lvl_en(lvl_en), .lvl_gain(lvl_gain), .pwr_mode(pwr_mode),
    .gain_left(gain_left), .gain_right(gain_right), .rd_gain(rd_gain)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gl = 16; m_gr = 16; m_rd = 16; m_pend = 16; m_cnt = 0;
      m_wl = 0; m_wr = 0; m_nl = 0; m_nr = 0;
    end else begin
      bit pon, arm, busy, zl, zr, to;
      int np, lim;
      pon = (pwr_mode != 0);
      arm = wr_en && !lvl_en && pon;
      busy = m_wl || m_wr;
      zl = smp_valid && (smp_left == 0 || ((smp_left < 0) != m_nl));
      zr = smp_valid && (smp_right == 0 || ((smp_right < 0) != m_nr));
      lim = 128 << tmo_sel;
      if (wr_en) m_rd = wr_gain;
      if (!pon) begin
        m_gl = 16; m_gr = 16; m_wl = 0; m_wr = 0; m_cnt = 0;
      end else begin
        np = arm ? int'(wr_gain) : m_pend;
        m_pend = np;
        if (arm && !busy) begin
          m_wl = 1; m_wr = 1; m_cnt = 0;
        end else if (busy && smp_valid) begin
          to = (m_cnt >= lim - 1);
          if (m_wl && (zl || to)) begin m_gl = np; m_wl = 0; end
          if (m_wr && (zr || to)) begin m_gr = np; m_wr = 0; end
          m_cnt = to ? 0 : m_cnt + 1;
        end
      end
      if (smp_valid) begin
        m_nl = (smp_left < 0);
        m_nr = (smp_right < 0);
      end
    end
    #1;
    if (rst_n) begin
      bit ov;
      ov = lvl_en && (pwr_mode != 0);
      chk(cur_req, gain_left, ov ? int'(lvl_gain) : m_gl);
      chk(cur_req, gain_right, ov ? int'(lvl_gain) : m_gr);
      chk("R4", rd_gain, m_rd);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(int g);
    wr_en = 1'b1; wr_gain = 7'(g);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe(int l, int r);
    smp_valid = 1'b1; smp_left = 16'(l); smp_right = 16'(r);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R7", gain_left, 16); chk("R7", gain_right, 16); chk("R7", rd_gain, 16);

    cur_req = "R1";
    wr(32);
    strobe(-5, 100);
    chk("R1", gain_left, 32); chk("R1", gain_right, 16);
    cur_req = "R2";
    repeat (126) strobe(-5, 100);
    chk("R2", gain_right, 16);
    strobe(-5, 100);
    chk("R2", gain_right, 32);

    cur_req = "R3";
    wr(48);
    strobe(5, 100);
    chk("R3", gain_left, 48);
    wr(64);
    repeat (126) strobe(5, 100);
    chk("R3", gain_right, 32); chk("R3", gain_left, 48);
    strobe(5, 100);
    chk("R3", gain_right, 64); chk("R3", gain_left, 48);
    chk("R4", rd_gain, 64);

    cur_req = "R1";
    wr(34);
    strobe(5, 0);
    chk("R1", gain_right, 34); chk("R1", gain_left, 48);
    strobe(-1, 7);
    chk("R1", gain_left, 34);

    cur_req = "R5";
    lvl_en = 1'b1; lvl_gain = 7'h55;
    tick();
    chk("R5", gain_left, 'h55); chk("R5", gain_right, 'h55);
    wr(17);
    chk("R4", rd_gain, 17);
    strobe(-3, -3);
    lvl_en = 1'b0;
    tick();
    chk("R5", gain_left, 34); chk("R5", gain_right, 34); chk("R5", rd_gain, 17);
    strobe(3, 3);
    chk("R5", gain_left, 34);

    cur_req = "R6";
    pwr_mode = 2'd0;
    tick();
    chk("R6", gain_left, 16); chk("R6", gain_right, 16);
    wr(102);
    chk("R4", rd_gain, 102);
    pwr_mode = 2'd1;
    tick();
    strobe(-3, -3);
    chk("R6", gain_left, 16); chk("R6", gain_right, 16);

    cur_req = "R2";
    tmo_sel = 2'd1;
    wr(7);
    repeat (255) strobe(-3, -3);
    chk("R2", gain_left, 16); chk("R2", gain_right, 16);
    strobe(-3, -3);
    chk("R2", gain_left, 7); chk("R2", gain_right, 7);

    cur_req = "R8";
    wr(18);
    smp_left = 16'sd9; smp_right = 16'sd0;
    repeat (3) tick();
    chk("R8", gain_left, 7); chk("R8", gain_right, 7);
    strobe(9, 9);
    chk("R8", gain_left, 18); chk("R8", gain_right, 18);

    cur_req = "R3";
    for (int i = 0; i < 4000; i++) begin
      wr_en = ($urandom_range(0, 40) == 0);
      wr_gain = 7'($urandom);
      smp_valid = ($urandom_range(0, 2) != 0);
      smp_left = ($urandom_range(0, 20) == 0) ? 16'sd0 :
                 (($urandom_range(0, 30) == 0) ? -16'sd100 : 16'sd100);
      smp_right = ($urandom_range(0, 25) == 0) ? -16'sd50 : 16'sd50;
      if ($urandom_range(0, 300) == 0) lvl_en = ~lvl_en;
      lvl_gain = 7'($urandom);
      if ($urandom_range(0, 400) == 0) pwr_mode = 2'($urandom_range(0, 3));
      if (pwr_mode == 0 && $urandom_range(0, 10) == 0) pwr_mode = 2'd2;
      if ($urandom_range(0, 500) == 0) tmo_sel = 2'($urandom);
      tick();
    end
    wr_en = 1'b0; smp_valid = 1'b0;
    tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule